// File: doc/BRIEF.md
# Snooping Write-Through Coherent Cache Cluster

This block joins several processor ports to one shared memory over a single bus. Each port has a small direct-mapped cache that stores one word per line and keeps only a valid bit as line state. Every processor write goes straight onto the bus and into memory in the same cycle, so memory always holds the newest value. Every cache watches the writes that other ports put on the bus and keeps its own copy coherent. The parameter `POLICY` picks how it does this. `COH_INVALIDATE` drops a matching line. `COH_UPDATE` overwrites the matching line with the bus data. Neither policy adds line states or bus commands.

Each processor port is a valid/ready request channel. A request is accepted in the cycle that both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the requester must hold `req_we`, `req_addr` and `req_wdata` steady. A read returns its data as a one-cycle `resp_valid` pulse in the cycle after acceptance. The response cannot be stalled. Writes produce no response. The bus is granted to one requester per cycle by a round-robin arbiter. Observation pins show the bus traffic.

Top module: `wt_coherent_sys`

## Requirements
- R1: After reset no `resp_valid` is high, no bus transaction is active, every cache line is invalid and every memory word reads 0.
- R2: A read miss is accepted in the cycle its bus read is granted. The line is filled from memory and marked valid, and the memory word is returned with `resp_valid` in the next cycle.
- R3: A read hit is accepted in the cycle it is presented, with no bus transaction, and the cached word is returned in the next cycle.
- R4: Every write is accepted only together with a bus write (`bus_act`=1, `bus_we`=1, `bus_gnt` bit set for that port) and updates memory at that clock edge. Later reads from any port return the new value.
- R5: A write to an address that the writer does not cache does not allocate a line, so the writer's next read of that address misses.
- R6: A write that hits in the writer's own cache updates its copy. The writer does not snoop its own transaction, so its next read of that address hits and returns the new value.
- R7: With `POLICY`=`COH_INVALIDATE`, a bus write from another port to an address a cache holds clears that line. The next read there misses and returns the memory value.
- R8: With `POLICY`=`COH_UPDATE`, a bus write from another port to an address a cache holds replaces the cached word. The next read there hits and returns the written value.
- R9: A snooped write whose address maps to a held line but whose tag differs leaves that line untouched.
- R10: Addresses map to line `addr[IW-1:0]` with tag `addr[AW-1:IW]`. A miss that fills a line evicts the previous address held there.
- R11: At most one `bus_gnt` bit is high per cycle, and only for a requesting port. After port k is granted, the search for the next grant starts at port k+1, wrapping. A port that is not granted sees `req_ready` low and keeps its request pending.
- R12: When two ports each add their own value (3 and 7) to a shared word that starts at 0, using read-then-write, a final read from either port returns 10 under both policies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Request valid, one bit per port |
| req_ready | output | NPROC | Request accepted this cycle |
| req_we | input | NPROC | 1 = write, 0 = read |
| req_addr | input | NPROC*AW | Word address, port i in bits [i*AW +: AW] |
| req_wdata | input | NPROC*DW | Write data, port i in bits [i*DW +: DW] |
| resp_valid | output | NPROC | Read data valid, one cycle after acceptance |
| resp_rdata | output | NPROC*DW | Read data, port i in bits [i*DW +: DW] |
| bus_act | output | 1 | A bus transaction occurs this cycle |
| bus_we | output | 1 | Current bus transaction is a write |
| bus_addr | output | AW | Address of current bus transaction |
| bus_gnt | output | NPROC | One-hot owner of the current bus transaction |

## Verification
The bench runs one stimulus stream through two instances, one for each policy, and compares read data against a memory model kept by the bench. Several corner cases get targeted checks:
- The shared-sum sequence. A cache that missed a snooped write would return 3 or 7 instead of 10.
- A hit read directly after a write from another port. A wrong policy shows up as bus activity on update, or as a silent hit on invalidate.
- A snooped write with the same index but a different tag. A cache that compares only the index would wrongly drop or corrupt its line.
- A write miss followed by a read. This exposes a cache that allocates on writes.
- Simultaneous requests to the same address. Here the final memory value reveals whether grant order rotates or is fixed priority.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [0:0] {
    COH_INVALIDATE = 1'b0,
    COH_UPDATE     = 1'b1
  } coh_policy_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int cand;
      cand = (int'(ptr) + k) % N;
      if (!found && req[cand]) begin
        gnt[cand] = 1'b1;
        win       = IW'(cand);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (found) begin
      ptr <= (win == IW'(N - 1)) ? '0 : win + IW'(1);
    end
  end
endmodule

// File: rtl/wt_memory.sv
module wt_memory #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  assign rdata = words[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) words[w] <= '0;
    end else if (wr_en) begin
      words[addr] <= wdata;
    end
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import coh_pkg::*;
#(
  parameter int          AW     = 4,
  parameter int          DW     = 8,
  parameter int          LINES  = 4,
  parameter coh_policy_e POLICY = COH_INVALIDATE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          snoop_wr,
  input  logic [AW-1:0] snoop_addr,
  input  logic [DW-1:0] snoop_data,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  logic [LINES-1:0] vld;
  logic [TW-1:0]    tags  [LINES];
  logic [DW-1:0]    words [LINES];

  logic [IW-1:0] idx, sidx;
  logic [TW-1:0] rtag, stag;
  logic          hit, snoop_hit, rd_fire, wr_fire;
  logic          snoop_clr, snoop_upd;

  assign idx  = req_addr[IW-1:0];
  assign rtag = req_addr[AW-1:IW];
  assign sidx = snoop_addr[IW-1:0];
  assign stag = snoop_addr[AW-1:IW];

  assign hit       = vld[idx] && (tags[idx] == rtag);
  assign snoop_hit = snoop_wr && vld[sidx] && (tags[sidx] == stag);

  assign bus_req   = req_valid && (req_we || !hit);
  assign req_ready = req_valid && ((!req_we && hit) || bus_gnt);
  assign rd_fire   = req_ready && !req_we;
  assign wr_fire   = req_ready && req_we;

  if (POLICY == COH_UPDATE) begin : g_update
    assign snoop_clr = 1'b0;
    assign snoop_upd = snoop_hit;
  end else begin : g_invalidate
    assign snoop_clr = snoop_hit;
    assign snoop_upd = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= rd_fire;
      if (rd_fire) resp_rdata <= hit ? words[idx] : mem_rdata;
      if (rd_fire && !hit) vld[idx] <= 1'b1;
      if (snoop_clr) vld[sidx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire && !hit) begin
      tags[idx]  <= rtag;
      words[idx] <= mem_rdata;
    end else if (wr_fire && hit) begin
      words[idx] <= req_wdata;
    end
    if (snoop_upd) words[sidx] <= snoop_data;
  end
endmodule

// File: rtl/wt_coherent_sys.sv
module wt_coherent_sys
  import coh_pkg::*;
#(
  parameter int          NPROC  = 2,
  parameter int          AW     = 4,
  parameter int          DW     = 8,
  parameter int          LINES  = 4,
  parameter coh_policy_e POLICY = COH_INVALIDATE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPROC-1:0]    req_valid,
  output logic [NPROC-1:0]    req_ready,
  input  logic [NPROC-1:0]    req_we,
  input  logic [NPROC*AW-1:0] req_addr,
  input  logic [NPROC*DW-1:0] req_wdata,
  output logic [NPROC-1:0]    resp_valid,
  output logic [NPROC*DW-1:0] resp_rdata,
  output logic                bus_act,
  output logic                bus_we,
  output logic [AW-1:0]       bus_addr,
  output logic [NPROC-1:0]    bus_gnt
);
  logic [NPROC-1:0] bus_req;
  logic [DW-1:0]    bus_wdata;
  logic [DW-1:0]    mem_rdata;

  rr_arbiter #(.N(NPROC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .gnt   (bus_gnt)
  );

  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int i = 0; i < NPROC; i++) begin
      if (bus_gnt[i]) begin
        bus_we    = req_we[i];
        bus_addr  = req_addr[i*AW +: AW];
        bus_wdata = req_wdata[i*DW +: DW];
      end
    end
  end

  assign bus_act = |bus_gnt;

  for (genvar g = 0; g < NPROC; g++) begin : g_port
    wt_cache #(
      .AW(AW), .DW(DW), .LINES(LINES), .POLICY(POLICY)
    ) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[g]),
      .req_ready  (req_ready[g]),
      .req_we     (req_we[g]),
      .req_addr   (req_addr[g*AW +: AW]),
      .req_wdata  (req_wdata[g*DW +: DW]),
      .resp_valid (resp_valid[g]),
      .resp_rdata (resp_rdata[g*DW +: DW]),
      .bus_req    (bus_req[g]),
      .bus_gnt    (bus_gnt[g]),
      .snoop_wr   (bus_act && bus_we && !bus_gnt[g]),
      .snoop_addr (bus_addr),
      .snoop_data (bus_wdata),
      .mem_rdata  (mem_rdata)
    );
  end

  wt_memory #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_act && bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/wt_coherent_chk.sv
module wt_coherent_chk #(
  parameter int NPROC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] req_valid,
  input logic [NPROC-1:0] req_ready,
  input logic [NPROC-1:0] req_we,
  input logic [NPROC-1:0] resp_valid,
  input logic             bus_act,
  input logic             bus_we,
  input logic [NPROC-1:0] bus_gnt
);
  // R11
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_valid) |-> !bus_act);

  for (genvar i = 0; i < NPROC; i++) begin : g_port
    // R11
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_gnt[i] |-> req_valid[i]);

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && !req_we[i]) |=> resp_valid[i]);

    // R2
    resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid[i] |-> $past(req_valid[i] && req_ready[i] && !req_we[i]));

    // R4
    wr_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && req_we[i]) |-> (bus_act && bus_we && bus_gnt[i]));
  end
endmodule

bind wt_coherent_sys wt_coherent_chk #(.NPROC(NPROC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_we     (req_we),
  .resp_valid (resp_valid),
  .bus_act    (bus_act),
  .bus_we     (bus_we),
  .bus_gnt    (bus_gnt)
);

// File: tb/sim_wt_coherent_sys.sv
module sim_wt_coherent_sys;
  import coh_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  // {port, we, addr[3:0], data[7:0], bus expected (invalidate), bus expected (update)}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd2, 8'h00, 1'b1, 1'b1},
    {1'b1, 1'b0, 4'd2, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 4'd2, 8'h03, 1'b1, 1'b1},
    {1'b1, 1'b0, 4'd2, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd2, 8'h0A, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd2, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'd2, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd2, 8'h0B, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd2, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9, 8'h55, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd9, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd5, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 1'b1},
    {1'b1, 1'b1, 4'd9, 8'hAA, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd6, 8'h21, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'd2, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd6, 8'h00, 1'b1, 1'b1}
  };

  localparam string TAGS [NV] = '{
    "R1 R2", "R2", "R4 R6", "R7 R8", "R12 R4", "R12 R7 R8", "R12 R3",
    "R6 R4", "R6 R3", "R4 R5", "R5", "R3", "R10", "R10",
    "R7 R8", "R7 R8", "R9 R5", "R9", "R2"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_valid = '0;
  logic [1:0]  req_we = '0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;

  logic [1:0]  rdy0, rdy1, rv0, rv1, gnt0, gnt1;
  logic [15:0] rd0, rd1;
  logic        ba0, ba1, bw0, bw1;
  logic [3:0]  bad0, bad1;

  logic [7:0] ref_mem [16];
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wt_coherent_sys #(.POLICY(COH_INVALIDATE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(rv0), .resp_rdata(rd0), .bus_act(ba0), .bus_we(bw0),
    .bus_addr(bad0), .bus_gnt(gnt0)
  );

  wt_coherent_sys #(.POLICY(COH_UPDATE)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(rv1), .resp_rdata(rd1), .bus_act(ba1), .bus_we(bw1),
    .bus_addr(bad1), .bus_gnt(gnt1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step(input int p, input bit we, input logic [3:0] addr,
                      input logic [7:0] wd, input bit exp_bi, input bit exp_bu,
                      input string tag);
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_we[p]    = we;
    req_addr[p*4 +: 4]  = addr;
    req_wdata[p*8 +: 8] = wd;
    #1;
    chk({"R11 ready inv ", tag}, 32'(rdy0[p]), 32'd1);
    chk({"R11 ready upd ", tag}, 32'(rdy1[p]), 32'd1);
    chk({"bus inv ", tag}, 32'(ba0), 32'(exp_bi));
    chk({"bus upd ", tag}, 32'(ba1), 32'(exp_bu));
    if (we) chk({"R4 bus write ", tag}, {30'd0, bw0, bw1}, 32'd3);
    @(negedge clk);
    req_valid = '0;
    if (!we) begin
      chk({"resp inv ", tag}, 32'(rv0[p]), 32'd1);
      chk({"resp upd ", tag}, 32'(rv1[p]), 32'd1);
      chk({"data inv ", tag}, 32'(rd0[p*8 +: 8]), 32'(ref_mem[addr]));
      chk({"data upd ", tag}, 32'(rd1[p*8 +: 8]), 32'(ref_mem[addr]));
    end else begin
      ref_mem[addr] = wd;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int w = 0; w < 16; w++) ref_mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 resp_valid inv", 32'(rv0), 32'd0);
    chk("R1 resp_valid upd", 32'(rv1), 32'd0);
    chk("R1 bus idle", {30'd0, ba0, ba1}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      step(int'(VEC[v][15]), VEC[v][14], VEC[v][13:10], VEC[v][9:2],
           VEC[v][1], VEC[v][0], TAGS[v]);
    end

    // R11: both ports write address 12 at once; port 0 goes first after reset order
    @(negedge clk);
    req_valid = 2'b11; req_we = 2'b11;
    req_addr = {4'd12, 4'd12}; req_wdata = {8'h22, 8'h11};
    #1;
    chk("R11 first grant", {28'd0, gnt0, gnt1}, 32'b0101);
    chk("R11 stalled ready", {28'd0, rdy0, rdy1}, 32'b0101);
    @(negedge clk);
    req_valid = 2'b10;
    #1;
    chk("R11 second grant", {28'd0, gnt0, gnt1}, 32'b1010);
    @(negedge clk);
    req_valid = '0;
    ref_mem[12] = 8'h22;

    step(0, 1'b1, 4'd14, 8'h01, 1'b1, 1'b1, "R11 R4");

    // R11: after port 0 wins, port 1 is searched first
    @(negedge clk);
    req_valid = 2'b11; req_we = 2'b11;
    req_addr = {4'd13, 4'd13}; req_wdata = {8'h44, 8'h33};
    #1;
    chk("R11 rotated grant", {28'd0, gnt0, gnt1}, 32'b1010);
    @(negedge clk);
    req_valid = 2'b01;
    #1;
    chk("R11 rotated second", {28'd0, gnt0, gnt1}, 32'b0101);
    @(negedge clk);
    req_valid = '0;
    ref_mem[13] = 8'h33;

    step(0, 1'b0, 4'd12, 8'h00, 1'b1, 1'b1, "R11 R4 order");
    step(1, 1'b0, 4'd13, 8'h00, 1'b1, 1'b1, "R11 R4 order");
    step(1, 1'b0, 4'd14, 8'h00, 1'b1, 1'b1, "R4");

    // R1: a second reset clears lines and memory
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 16; w++) ref_mem[w] = '0;
    step(1, 1'b0, 4'd6, 8'h00, 1'b1, 1'b1, "R1 after reset");

    summary();
  end
endmodule